// File: doc/BRIEF.md
# Infrared Pulse-Width Capture Controller

This block watches one active-low infrared receiver pin and records how long each mark (pin low) and each space (pin high) lasts. Durations are counted in ticks of a programmable prescaler. Each duration is saved as one saturating byte in a bank of 32-bit capture words. When a space lasts long enough to count as idle, the message is closed with a zero byte and a pending interrupt is raised. Software reads the capture words, acknowledges the interrupt and writes a restart to arm the block for the next message.

The pin passes through a two-flop synchronizer and a de-glitch filter. The filtered falling and rising edges then drive a state machine with six states:
- OFF: disabled, or frozen after a disable with data still held.
- ARMED: waiting for the first falling edge.
- MARK: timing a pulse.
- SPACE: timing a gap.
- FULL: all entries are stored and edges are dropped.
- DONE: the message is complete and waits for a restart.

Transitions:
- OFF to ARMED when the block is enabled and no entry is stored.
- ARMED to MARK on a falling edge.
- MARK to SPACE on a rising edge.
- SPACE to MARK on a falling edge.
- MARK or SPACE to FULL when the last entry is written.
- SPACE to DONE on idle.
- FULL to DONE on idle while the pin is high.
- Any state to OFF on disable.
- Any state to ARMED (or to OFF if disabled) on restart.

Top module: `irpw_capture_top`

## Requirements
- R1: Stored entries alternate, with entry 0 a mark and entry 1 a space. Each entry holds floor(D/(div+1)), where D is the duration in clocks and div is the prescaler value at byte offset 0x08. Capture word i sits at byte offset 0x40+4*i and holds entry 4i in bits 7:0, up to entry 4i+3 in bits 31:24.
- R2: A duration whose tick count exceeds 255 is stored as 0xFF.
- R3: The bank holds 17 words, which is 68 entries. Once entry 67 is stored, later edges are dropped and the bank is unchanged. An idle space after that still completes the message and sets the pending flag.
- R4: A space that reaches idle_lim ticks closes the message. idle_lim is a 7-bit field at bits 22:16 of the control word at offset 0x00, and a value of 0 disables the idle check. That space is stored as 0x00, every later entry reads 0, and the pending flag is set.
- R5: A level change on the pin is accepted only after the new level has held for dg+1 consecutive clocks. dg is bits 12:8 of the word at offset 0x04. Shorter glitches are ignored and fold into the surrounding duration.
- R6: Writing 1 to bit 0 at offset 0x0C zeroes every capture word and clears the entry index. Capture then begins only at the first falling edge that follows.
- R7: The irq output equals the pending flag gated by bit 0 at offset 0x10. Writing 1 to bit 0 at offset 0x14 clears the pending flag.
- R8: After a message completes, edges are ignored and the bank stays unchanged until a restart.
- R9: Capture runs only when bit 0 (receiver on) and bit 13 (width measurement on) of the control word are both 1. Otherwise edges are ignored.
- R10: After reset, the control word reads 0, the prescaler reads 0xFF, every capture word reads 0 and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_n | input | 1 | Raw receiver pin, low during a mark |
| bus_addr | input | 8 | Byte address of the register port |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 1 | Message-complete interrupt |

## Verification
The assertions rely on restart and acknowledge arriving only as one-cycle pulses from the register port. They also rely on the entry index advancing only through stores made by the state machine. The stimulus keeps every random mark and space longer than the de-glitch window and shorter than the idle limit, so only the trailing gap ends a message. The prescaler, filter and idle limit are programmed before any edge is driven. Glitches and overlong pulses appear only in directed cases whose expected bytes are worked out from the same floor-and-saturate rule.

// File: rtl/irpw_pkg.sv
package irpw_pkg;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_ARMED = 3'd1,
        ST_MARK  = 3'd2,
        ST_SPACE = 3'd3,
        ST_FULL  = 3'd4,
        ST_DONE  = 3'd5
    } irpw_state_e;

    // byte offsets of the register port
    localparam int OFS_CTRL    = 'h00;
    localparam int OFS_FILT    = 'h04;
    localparam int OFS_TICK    = 'h08;
    localparam int OFS_RESTART = 'h0C;
    localparam int OFS_IEN     = 'h10;
    localparam int OFS_IACK    = 'h14;
    localparam int OFS_CAP     = 'h40;

    // field positions software relies on
    localparam int CTRL_RX_BIT  = 0;
    localparam int CTRL_PW_BIT  = 13;
    localparam int CTRL_LIM_LSB = 16;
    localparam int FILT_DG_LSB  = 8;

endpackage

// File: rtl/irpw_front.sv
module irpw_front #(
    parameter int DG_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ir_n,
    input  logic [DG_W-1:0] dg_lim,
    output logic            level,
    output logic            fall_p,
    output logic            rise_p
);

    logic [1:0]      sync_q;
    logic [DG_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
        end else begin
            sync_q <= {sync_q[0], ir_n};
        end
    end

    // accept a new level after dg_lim+1 consecutive differing samples
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level  <= 1'b1;
            run_q  <= '0;
            fall_p <= 1'b0;
            rise_p <= 1'b0;
        end else begin
            fall_p <= 1'b0;
            rise_p <= 1'b0;
            if (sync_q[1] != level) begin
                if (run_q == dg_lim) begin
                    level  <= sync_q[1];
                    run_q  <= '0;
                    fall_p <= level;
                    rise_p <= ~level;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end else begin
                run_q <= '0;
            end
        end
    end

endmodule

// File: rtl/irpw_regs.sv
module irpw_regs
    import irpw_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter int                TICK_W     = 16,
    parameter logic [TICK_W-1:0] TICK_RESET = 'hFF,
    parameter int                LIM_W      = 7,
    parameter int                DG_W       = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic              rx_en,
    output logic              pw_en,
    output logic [LIM_W-1:0]  idle_lim,
    output logic [DG_W-1:0]   dg_lim,
    output logic [TICK_W-1:0] div,
    output logic              irq_en,
    output logic              restart_p,
    output logic              ack_p,
    output logic [31:0]       rdata
);

    logic unused_wdata;
    assign unused_wdata = ^wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_en     <= 1'b0;
            pw_en     <= 1'b0;
            idle_lim  <= '0;
            dg_lim    <= '0;
            div       <= TICK_RESET;
            irq_en    <= 1'b0;
            restart_p <= 1'b0;
            ack_p     <= 1'b0;
        end else begin
            restart_p <= wr_en && (addr == ADDR_W'(OFS_RESTART)) && wdata[0];
            ack_p     <= wr_en && (addr == ADDR_W'(OFS_IACK)) && wdata[0];
            if (wr_en) begin
                unique case (addr)
                    ADDR_W'(OFS_CTRL): begin
                        rx_en    <= wdata[CTRL_RX_BIT];
                        pw_en    <= wdata[CTRL_PW_BIT];
                        idle_lim <= wdata[CTRL_LIM_LSB +: LIM_W];
                    end
                    ADDR_W'(OFS_FILT): dg_lim <= wdata[FILT_DG_LSB +: DG_W];
                    ADDR_W'(OFS_TICK): div    <= wdata[TICK_W-1:0];
                    ADDR_W'(OFS_IEN):  irq_en <= wdata[0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            ADDR_W'(OFS_CTRL): begin
                rdata[CTRL_RX_BIT]                 = rx_en;
                rdata[CTRL_PW_BIT]                 = pw_en;
                rdata[CTRL_LIM_LSB +: LIM_W]       = idle_lim;
            end
            ADDR_W'(OFS_FILT): rdata[FILT_DG_LSB +: DG_W] = dg_lim;
            ADDR_W'(OFS_TICK): rdata[TICK_W-1:0]          = div;
            ADDR_W'(OFS_IEN):  rdata[0]                   = irq_en;
            default: ;
        endcase
    end

endmodule

// File: rtl/irpw_bank.sv
module irpw_bank #(
    parameter int WORDS  = 17,
    parameter int ENT    = 4 * WORDS,
    parameter int IDX_W  = $clog2(ENT + 1),
    parameter int WSEL_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [7:0]        wdata,
    input  logic [WSEL_W-1:0] rsel,
    output logic [31:0]       rword
);

    logic [7:0] ent_q [ENT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < ENT; e++) ent_q[e] <= '0;
        end else if (clr) begin
            for (int e = 0; e < ENT; e++) ent_q[e] <= '0;
        end else if (we) begin
            ent_q[widx] <= wdata;
        end
    end

    // earliest entry of each word in the low byte
    always_comb begin
        rword = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (rsel == WSEL_W'(w)) begin
                rword = {ent_q[4*w+3], ent_q[4*w+2], ent_q[4*w+1], ent_q[4*w]};
            end
        end
    end

endmodule

// File: rtl/irpw_fsm.sv
module irpw_fsm
    import irpw_pkg::*;
#(
    parameter int TICK_W = 16,
    parameter int LIM_W  = 7,
    parameter int ENT    = 68,
    parameter int IDX_W  = 7,
    parameter int WID_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              restart,
    input  logic              fall_p,
    input  logic              rise_p,
    input  logic              level,
    input  logic [TICK_W-1:0] div,
    input  logic [LIM_W-1:0]  idle_lim,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [WID_W-1:0]  wr_data,
    output logic              set_pend,
    output irpw_state_e       state_o,
    output logic [IDX_W-1:0]  idx_o
);

    localparam logic [WID_W-1:0] WID_MAX  = '1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ENT - 1);

    irpw_state_e       state_q, nxt;
    logic [IDX_W-1:0]  idx_q;
    logic [TICK_W-1:0] cnt_q;
    logic [WID_W-1:0]  wid_q, wid_inc;
    logic              tick, idle_hit, last, running;
    logic              clr_cnt, idx_inc;

    assign tick    = (cnt_q == div);
    assign last    = (idx_q == IDX_LAST);
    assign running = (state_q == ST_MARK) || (state_q == ST_SPACE) || (state_q == ST_FULL);

    always_comb begin
        wid_inc = wid_q;
        if (tick && (wid_q != WID_MAX)) wid_inc = wid_q + 1'b1;
    end

    assign idle_hit = tick && (idle_lim != '0) && (wid_inc == WID_W'(idle_lim));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= nxt;
    end

    // next state and outputs
    always_comb begin
        nxt      = state_q;
        wr_en    = 1'b0;
        wr_data  = wid_inc;
        set_pend = 1'b0;
        clr_cnt  = 1'b0;
        idx_inc  = 1'b0;
        if (restart) begin
            nxt     = active ? ST_ARMED : ST_OFF;
            clr_cnt = 1'b1;
        end else if (!active) begin
            nxt     = ST_OFF;
            clr_cnt = 1'b1;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    if (idx_q == '0) nxt = ST_ARMED;
                end
                ST_ARMED: begin
                    if (fall_p) begin
                        nxt     = ST_MARK;
                        clr_cnt = 1'b1;
                    end
                end
                ST_MARK: begin
                    if (rise_p) begin
                        wr_en   = 1'b1;
                        idx_inc = 1'b1;
                        clr_cnt = 1'b1;
                        nxt     = last ? ST_FULL : ST_SPACE;
                    end
                end
                ST_SPACE: begin
                    if (idle_hit) begin
                        wr_en    = 1'b1;
                        wr_data  = '0;
                        set_pend = 1'b1;
                        nxt      = ST_DONE;
                    end else if (fall_p) begin
                        wr_en   = 1'b1;
                        idx_inc = 1'b1;
                        clr_cnt = 1'b1;
                        nxt     = last ? ST_FULL : ST_MARK;
                    end
                end
                ST_FULL: begin
                    if (fall_p || rise_p) begin
                        clr_cnt = 1'b1;
                    end else if (level && idle_hit) begin
                        set_pend = 1'b1;
                        nxt      = ST_DONE;
                    end
                end
                ST_DONE: ;
                default: nxt = ST_OFF;
            endcase
        end
    end

    // datapath: entry index, prescaler, width counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            cnt_q <= '0;
            wid_q <= '0;
        end else begin
            if (restart)      idx_q <= '0;
            else if (idx_inc) idx_q <= idx_q + 1'b1;

            if (clr_cnt || !running) begin
                cnt_q <= '0;
                wid_q <= '0;
            end else if (tick) begin
                cnt_q <= '0;
                wid_q <= wid_inc;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign wr_idx  = idx_q;
    assign state_o = state_q;
    assign idx_o   = idx_q;

endmodule

// File: rtl/irpw_capture_top.sv
module irpw_capture_top
    import irpw_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter int                TICK_W     = 16,
    parameter logic [TICK_W-1:0] TICK_RESET = 'hFF,
    parameter int                CAP_WORDS  = 17,
    parameter int                LIM_W      = 7,
    parameter int                DG_W       = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ir_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);

    localparam int CAP_ENTRIES = 4 * CAP_WORDS;
    localparam int IDX_W       = $clog2(CAP_ENTRIES + 1);
    localparam int WSEL_W      = $clog2(CAP_WORDS);
    localparam int WA_W        = ADDR_W - 2;

    logic              rx_en, pw_en, irq_en, restart_p, ack_p, active;
    logic [LIM_W-1:0]  idle_lim;
    logic [DG_W-1:0]   dg_lim;
    logic [TICK_W-1:0] div;
    logic [31:0]       cfg_rdata, cap_rdata;
    logic              level, fall_p, rise_p;
    logic              wr_en, set_pend, pending_q;
    logic [IDX_W-1:0]  wr_idx, idx_w;
    logic [7:0]        wr_data;
    irpw_state_e       state_w;
    logic [WA_W-1:0]   word_addr, cap_off;
    logic              cap_hit;
    logic              unused_lsb;

    assign active = rx_en & pw_en;

    irpw_regs #(
        .ADDR_W(ADDR_W), .TICK_W(TICK_W), .TICK_RESET(TICK_RESET),
        .LIM_W(LIM_W), .DG_W(DG_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .rx_en(rx_en), .pw_en(pw_en), .idle_lim(idle_lim), .dg_lim(dg_lim), .div(div),
        .irq_en(irq_en), .restart_p(restart_p), .ack_p(ack_p), .rdata(cfg_rdata)
    );

    irpw_front #(.DG_W(DG_W)) u_front (
        .clk(clk), .rst_n(rst_n), .ir_n(ir_n), .dg_lim(dg_lim),
        .level(level), .fall_p(fall_p), .rise_p(rise_p)
    );

    irpw_fsm #(
        .TICK_W(TICK_W), .LIM_W(LIM_W), .ENT(CAP_ENTRIES), .IDX_W(IDX_W), .WID_W(8)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .active(active), .restart(restart_p),
        .fall_p(fall_p), .rise_p(rise_p), .level(level), .div(div), .idle_lim(idle_lim),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .set_pend(set_pend),
        .state_o(state_w), .idx_o(idx_w)
    );

    assign word_addr  = bus_addr[ADDR_W-1:2];
    assign cap_off    = word_addr - WA_W'(OFS_CAP / 4);
    assign cap_hit    = (word_addr >= WA_W'(OFS_CAP / 4)) && (cap_off < WA_W'(CAP_WORDS));
    assign unused_lsb = ^bus_addr[1:0];

    irpw_bank #(.WORDS(CAP_WORDS), .ENT(CAP_ENTRIES), .IDX_W(IDX_W), .WSEL_W(WSEL_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .clr(restart_p), .we(wr_en), .widx(wr_idx),
        .wdata(wr_data), .rsel(cap_off[WSEL_W-1:0]), .rword(cap_rdata)
    );

    // completion flag: a new completion wins over a same-cycle acknowledge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pending_q <= 1'b0;
        else if (set_pend) pending_q <= 1'b1;
        else if (ack_p)    pending_q <= 1'b0;
    end

    assign irq       = pending_q & irq_en;
    assign bus_rdata = cap_hit ? cap_rdata : cfg_rdata;

endmodule

// File: rtl/irpw_checker.sv
module irpw_checker
    import irpw_pkg::*;
#(
    parameter int ENT   = 68,
    parameter int IDX_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input irpw_state_e      state,
    input logic [IDX_W-1:0] idx,
    input logic             pending,
    input logic             restart_p,
    input logic             ack_p,
    input logic             active
);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= IDX_W'(ENT)); // R3

    AST_FULL_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FULL) |-> (idx == IDX_W'(ENT))); // R3

    AST_PEND_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> (state == ST_DONE)); // R4

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_p && state == ST_DONE) |=> !pending); // R7

    AST_RESTART_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
        restart_p |=> (idx == '0) && (state == ST_ARMED || state == ST_OFF)); // R6

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && active && !restart_p) |=> (state == ST_DONE)); // R8

    AST_DISABLED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (state == ST_OFF)); // R9

endmodule

bind irpw_capture_top irpw_checker #(.ENT(CAP_ENTRIES), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state_w), .idx(idx_w), .pending(pending_q),
    .restart_p(restart_p), .ack_p(ack_p), .active(active)
);

// File: tb/irpw_capture_top_tb_top.sv
module irpw_capture_top_tb_top;

    localparam int DIV = 3;
    localparam int P   = DIV + 1;
    localparam int DG  = 2;
    localparam int LIM = 20;
    localparam int ENT = 68;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ir_n;
    logic [7:0]  bus_addr;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    int msg [0:199];
    int exp_ent [0:ENT-1];

    always #10 clk = ~clk;

    irpw_capture_top dut_i (
        .clk(clk), .rst_n(rst_n), .ir_n(ir_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic hold(logic v, int n);
        ir_n = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic restart_ack();
        wr(8'h14, 32'h1);
        wr(8'h0C, 32'h1);
    endtask

    // odd n: starts and ends with a mark, then a long idle gap
    task automatic play(int n);
        for (int k = 0; k < n; k++) hold((k % 2) != 0, msg[k]);
        hold(1'b1, 200);
    endtask

    function automatic int sat_w(int d);
        return (d / P > 255) ? 255 : d / P;
    endfunction

    task automatic expect_msg(int n);
        for (int e = 0; e < ENT; e++) exp_ent[e] = (e < n) ? sat_w(msg[e]) : 0;
    endtask

    task automatic expect_zero();
        for (int e = 0; e < ENT; e++) exp_ent[e] = 0;
    endtask

    task automatic check_bank(string tag);
        logic [31:0] v;
        for (int w = 0; w < ENT / 4; w++) begin
            rd(8'(8'h40 + 4 * w), v);
            chk(tag, v, {exp_ent[4*w+3][7:0], exp_ent[4*w+2][7:0],
                         exp_ent[4*w+1][7:0], exp_ent[4*w][7:0]});
        end
    endtask

    task automatic chk_irq(string tag, logic exp);
        @(negedge clk);
        chk(tag, {31'b0, irq}, {31'b0, exp});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd4242));
        rst_n = 1'b0; ir_n = 1'b1; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        rd(8'h00, v); chk("R10 ctrl", v, 32'h0);
        rd(8'h08, v); chk("R10 tick", v, 32'hFF);
        expect_zero(); check_bank("R10 bank");
        chk_irq("R10 irq", 1'b0);

        wr(8'h08, DIV);
        wr(8'h04, DG << 8);
        wr(8'h10, 32'h1);
        wr(8'h00, (LIM << 16) | (1 << 13) | 1);

        // R1 directed message, R4 idle close
        msg[0:4] = '{12, 40, 16, 33, 64};
        play(5); expect_msg(5); check_bank("R1 directed");
        chk_irq("R4 idle irq", 1'b1);
        wr(8'h14, 32'h1); chk_irq("R7 ack", 1'b0);

        // R8 ignored while complete
        msg[0:2] = '{50, 50, 50};
        play(3); check_bank("R8 unchanged"); chk_irq("R8 no new irq", 1'b0);
        wr(8'h0C, 32'h1); expect_zero(); check_bank("R6 cleared");

        // R7 gating by enable
        wr(8'h10, 32'h0);
        msg[0:2] = '{20, 20, 20};
        play(3); chk_irq("R7 gated", 1'b0);
        wr(8'h10, 32'h1); chk_irq("R7 ungated", 1'b1);
        restart_ack();

        // R2 saturation
        msg[0:2] = '{1200, 20, 40};
        play(3); expect_msg(3); check_bank("R2 saturate");
        restart_ack();

        // R5 short glitch folds into mark
        hold(1'b0, 20); hold(1'b1, 2); hold(1'b0, 20); hold(1'b1, 30); hold(1'b0, 24); hold(1'b1, 200);
        expect_zero(); exp_ent[0] = 42 / P; exp_ent[1] = 30 / P; exp_ent[2] = 24 / P;
        check_bank("R5 glitch rejected");
        restart_ack();
        // R5 longer pulse accepted
        hold(1'b0, 20); hold(1'b1, 4); hold(1'b0, 20); hold(1'b1, 200);
        expect_zero(); exp_ent[0] = 5; exp_ent[1] = 1; exp_ent[2] = 5;
        check_bank("R5 edge accepted");

        // R6 pin low at restart: wait for the next falling edge
        hold(1'b0, 5);
        wr(8'h14, 32'h1); wr(8'h0C, 32'h1);
        hold(1'b0, 30); hold(1'b1, 30);
        msg[0:2] = '{24, 36, 48};
        play(3); expect_msg(3); check_bank("R6 armed on fall");
        restart_ack();

        // R9 width measurement off
        wr(8'h00, (LIM << 16) | 1);
        msg[0:2] = '{30, 30, 30};
        play(3); expect_zero(); check_bank("R9 disabled"); chk_irq("R9 irq", 1'b0);
        wr(8'h00, (LIM << 16) | (1 << 13) | 1);

        // R3 overflow
        for (int k = 0; k < 81; k++) msg[k] = 8 + int'($urandom % 33);
        play(81); expect_msg(81); check_bank("R3 overflow");
        chk_irq("R3 irq after full", 1'b1);
        restart_ack();

        // R1 random messages
        for (int r = 0; r < 4; r++) begin
            int n;
            n = 3 + 2 * int'($urandom % 20);
            for (int k = 0; k < n; k++) msg[k] = 8 + int'($urandom % 63);
            play(n); expect_msg(n); check_bank("R1 random");
            chk_irq("R4 random irq", 1'b1);
            restart_ack();
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule